// File: doc/BRIEF.md
# Dual-Channel Edge-Programmable PWM Generator

This block produces two pulse-width-modulated outputs from one shared time base. A prescaler divides the input clock by a power of two from 1 to 128, and each prescaled tick advances a 16-bit counter. The counter can run upward, downward, up-and-down (triangle), or stand frozen. Two compare values are matched against the counter. Each output has its own small table of actions, and that table says what happens to the output when the counter passes zero or meets either compare value while rising.

Each compare value is either written straight into use or parked in a shadow copy. The shadow copy moves into use only on a chosen counter event, so a new duty value never cuts a pulse short in mid-cycle. All configuration arrives over a plain write port with an address, a data word and a strobe. Every register write takes effect on the clock edge that captures it.

Top module: `dpwm_gen`

## Requirements
- R1: After reset both outputs are low, the counter is frozen (control register = 3), and the outputs stay low until a write starts the counter.
- R2: Control register (address 0) bits [4:2] hold a divide select k. The counter advances once every 2^k clocks, for k from 0 to 7.
- R3: Control bits [1:0] select the counting mode: 0 = up, 1 = down, 2 = up-down, 3 = frozen. The period register (address 1) holds P. Up mode and down mode repeat every P+1 ticks. Up-down mode repeats every 2P ticks and turns around at P and at 0.
- R4: Action register for output A (address 4) and for output B (address 5). Bits [1:0] act on the counter-at-zero event, bits [3:2] act on the compare-A match, and bits [5:4] act on the compare-B match. Each action code means 0 = nothing, 1 = drive low, 2 = drive high, 3 = toggle.
- R5: At reset output A has actions "high at zero, low at compare A" (0x06) and output B has "high at zero, low at compare B" (0x12). In up mode, compare value C then gives C ticks high out of every P+1 ticks.
- R6: A compare match is an event only while the counter is rising. In down mode no compare event occurs. In up-down mode a match on the falling half is ignored.
- R7: When several events of one output fall on the same tick, the compare-B action wins over the compare-A action, and the compare-A action wins over the zero action. An event whose code is 0 does not take part. Compare A = 0 with the default actions therefore keeps output A low.
- R8: Compare A is written at address 2 and compare B at address 3. When the shadow bit is clear (control bit 5 for A, bit 6 for B), a write takes effect on the next tick, including during the current pulse.
- R9: When the shadow bit is set, a write goes only to the shadow copy. The shadow copy moves into use according to the load field (control bits [8:7] for A, [10:9] for B): 0 = at counter zero, 1 = at counter equal to period, 2 = at either, 3 = never.
- R10: While the counter is frozen, no events occur, and the counter and both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The hardest case to reach from the ports is a compare write that lands while a pulse is already high. In that case the immediate and shadowed modes must give different results for the pulse in progress and for the one after it. The stimulus waits for a rising edge on output A and issues the compare write in that same cycle. It then measures the current pulse and the next one, first with the shadow copy locked (load mode never), then with loading at the period event and at the zero event. Collisions between events are brought about by giving both compares the same value, and by setting a compare to zero.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

   localparam int NUM_CH   = 2;

   localparam int ADR_CTL  = 0;
   localparam int ADR_PRD  = 1;
   localparam int ADR_CMP0 = 2;
   localparam int ADR_ACT0 = 4;

   typedef enum logic [1:0] {
      CM_UP     = 2'd0,
      CM_DOWN   = 2'd1,
      CM_UPDOWN = 2'd2,
      CM_FREEZE = 2'd3
   } cnt_mode_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_LOW    = 2'd1,
      ACT_HIGH   = 2'd2,
      ACT_TOGGLE = 2'd3
   } act_e;

   typedef enum logic [1:0] {
      LD_ZERO  = 2'd0,
      LD_PRD   = 2'd1,
      LD_BOTH  = 2'd2,
      LD_NEVER = 2'd3
   } ld_mode_e;

   typedef struct packed {
      act_e on_cmpb;
      act_e on_cmpa;
      act_e on_zero;
   } act_cfg_t;

   function automatic logic act_apply(input act_e a, input logic cur);
      case (a)
         ACT_LOW:    return 1'b0;
         ACT_HIGH:   return 1'b1;
         ACT_TOGGLE: return ~cur;
         default:    return cur;
      endcase
   endfunction

endpackage

// File: rtl/dpwm_cfg.sv
module dpwm_cfg
   import dpwm_pkg::*;
#(
   parameter int CW      = 16,
   parameter int AW      = 3,
   parameter int DIVW    = 3,
   parameter int RST_PRD = 999
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [CW-1:0]   wr_data,
   output cnt_mode_e       mode,
   output logic [DIVW-1:0] div_sel,
   output logic [CW-1:0]   prd,
   output logic            shd_en  [NUM_CH],
   output ld_mode_e        ld_mode [NUM_CH],
   output act_cfg_t        act_cfg [NUM_CH]
);
   localparam int CTLW   = 2 + DIVW + 3 * NUM_CH;
   localparam int SHD_LO = 2 + DIVW;
   localparam int LD_LO  = SHD_LO + NUM_CH;
   localparam int ACTW   = $bits(act_cfg_t);

   logic [CTLW-1:0] ctl_q;
   logic [CW-1:0]   prd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= CTLW'(CM_FREEZE);
         prd_q <= CW'(RST_PRD);
      end else if (wr_en) begin
         if (wr_addr == AW'(ADR_CTL)) ctl_q <= wr_data[CTLW-1:0];
         if (wr_addr == AW'(ADR_PRD)) prd_q <= wr_data;
      end
   end

   assign mode    = cnt_mode_e'(ctl_q[1:0]);
   assign div_sel = ctl_q[2 +: DIVW];
   assign prd     = prd_q;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam act_cfg_t RST_ACT = (i == 0)
         ? '{on_cmpb: ACT_NONE, on_cmpa: ACT_LOW,  on_zero: ACT_HIGH}
         : '{on_cmpb: ACT_LOW,  on_cmpa: ACT_NONE, on_zero: ACT_HIGH};
      act_cfg_t act_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            act_q <= RST_ACT;
         else if (wr_en && wr_addr == AW'(ADR_ACT0 + i))
            act_q <= act_cfg_t'(wr_data[ACTW-1:0]);
      end

      assign act_cfg[i] = act_q;
      assign shd_en[i]  = ctl_q[SHD_LO + i];
      assign ld_mode[i] = ld_mode_e'(ctl_q[LD_LO + 2*i +: 2]);
   end

endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
   import dpwm_pkg::*;
#(
   parameter int CW   = 16,
   parameter int DIVW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  cnt_mode_e       mode,
   input  logic [DIVW-1:0] div_sel,
   input  logic [CW-1:0]   prd,
   output logic            tick,
   output logic [CW-1:0]   cnt,
   output logic            cnt_up,
   output logic            ev_zero,
   output logic            ev_prd
);
   localparam int PSW = (1 << DIVW) - 1;

   logic [PSW-1:0] ps_q;
   logic [PSW-1:0] ps_lim;
   logic [CW-1:0]  cnt_q;
   logic           dir_q;
   logic           frozen;

   assign frozen = (mode == CM_FREEZE);
   assign ps_lim = {PSW{1'b1}} >> (PSW - int'(div_sel));
   assign tick   = !frozen && (ps_q >= ps_lim);

   always_ff @(posedge clk) begin
      if (!rst_n)                ps_q <= '0;
      else if (frozen || tick)   ps_q <= '0;
      else                       ps_q <= ps_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b1;
      end else if (tick) begin
         case (mode)
            CM_UP: begin
               dir_q <= 1'b1;
               cnt_q <= (cnt_q >= prd) ? '0 : cnt_q + 1'b1;
            end
            CM_DOWN: begin
               dir_q <= 1'b0;
               cnt_q <= (cnt_q == '0) ? prd : cnt_q - 1'b1;
            end
            CM_UPDOWN: begin
               if (dir_q) begin
                  if (cnt_q >= prd) begin
                     dir_q <= 1'b0;
                     cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end else begin
                  if (cnt_q == '0) begin
                     dir_q <= 1'b1;
                     cnt_q <= (prd == '0) ? '0 : CW'(1);
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
            end
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt     = cnt_q;
   assign cnt_up  = (mode == CM_UP) || (mode == CM_UPDOWN && dir_q);
   assign ev_zero = tick && (cnt_q == '0);
   assign ev_prd  = tick && (cnt_q == prd);

endmodule

// File: rtl/dpwm_cmp.sv
module dpwm_cmp
   import dpwm_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [CW-1:0] wr_data,
   input  logic          shd_en,
   input  ld_mode_e      ld_mode,
   input  logic          tick,
   input  logic          cnt_up,
   input  logic [CW-1:0] cnt,
   input  logic          ev_zero,
   input  logic          ev_prd,
   output logic [CW-1:0] active,
   output logic          ev_match
);
   logic [CW-1:0] shadow_q;
   logic [CW-1:0] active_q;
   logic          load;

   always_comb begin
      case (ld_mode)
         LD_ZERO: load = ev_zero;
         LD_PRD:  load = ev_prd;
         LD_BOTH: load = ev_zero || ev_prd;
         default: load = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         active_q <= '0;
      end else if (wr && !shd_en) begin
         shadow_q <= wr_data;
         active_q <= wr_data;
      end else begin
         if (wr)   shadow_q <= wr_data;
         if (load) active_q <= shadow_q;
      end
   end

   assign active   = active_q;
   assign ev_match = tick && cnt_up && (cnt == active_q);

endmodule

// File: rtl/dpwm_aq.sv
module dpwm_aq
   import dpwm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_zero,
   input  logic [NUM_CH-1:0] ev_cmp,
   input  act_cfg_t          cfg,
   output logic              pwm
);
   act_e sel;
   logic pwm_q;

   always_comb begin
      sel = ACT_NONE;
      if (ev_zero   && cfg.on_zero != ACT_NONE) sel = cfg.on_zero;
      if (ev_cmp[0] && cfg.on_cmpa != ACT_NONE) sel = cfg.on_cmpa;
      if (ev_cmp[1] && cfg.on_cmpb != ACT_NONE) sel = cfg.on_cmpb;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pwm_q <= 1'b0;
      else        pwm_q <= act_apply(sel, pwm_q);
   end

   assign pwm = pwm_q;

endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen
   import dpwm_pkg::*;
#(
   parameter int CW      = 16,
   parameter int AW      = 3,
   parameter int DIVW    = 3,
   parameter int RST_PRD = 999
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [CW-1:0] wr_data,
   output logic          pwm_a,
   output logic          pwm_b
);
   localparam int CTLW = 2 + DIVW + 3 * NUM_CH;

   if (CW < 2 || CW > 32) begin : g_bad_cw
      $error("dpwm_gen: CW must lie in 2..32");
   end
   if (DIVW < 1 || DIVW > 4) begin : g_bad_divw
      $error("dpwm_gen: DIVW must lie in 1..4");
   end
   if (CTLW > CW) begin : g_bad_ctlw
      $error("dpwm_gen: control word does not fit the data width");
   end
   if (AW < 3) begin : g_bad_aw
      $error("dpwm_gen: address width too small for the register set");
   end
   if (RST_PRD < 0) begin : g_bad_prd
      $error("dpwm_gen: reset period must not be negative");
   end

   cnt_mode_e         mode;
   logic [DIVW-1:0]   div_sel;
   logic [CW-1:0]     prd;
   logic              shd_en  [NUM_CH];
   ld_mode_e          ld_mode [NUM_CH];
   act_cfg_t          act_cfg [NUM_CH];

   logic              tick;
   logic [CW-1:0]     cnt;
   logic              cnt_up;
   logic              ev_zero;
   logic              ev_prd;
   logic [CW-1:0]     cmp_act [NUM_CH];
   logic [NUM_CH-1:0] ev_cmp;
   logic [NUM_CH-1:0] pwm;

   dpwm_cfg #(.CW(CW), .AW(AW), .DIVW(DIVW), .RST_PRD(RST_PRD)) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .mode    (mode),
      .div_sel (div_sel),
      .prd     (prd),
      .shd_en  (shd_en),
      .ld_mode (ld_mode),
      .act_cfg (act_cfg)
   );

   dpwm_timebase #(.CW(CW), .DIVW(DIVW)) tb_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .div_sel (div_sel),
      .prd     (prd),
      .tick    (tick),
      .cnt     (cnt),
      .cnt_up  (cnt_up),
      .ev_zero (ev_zero),
      .ev_prd  (ev_prd)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
      dpwm_cmp #(.CW(CW)) cmp_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (wr_en && wr_addr == AW'(ADR_CMP0 + i)),
         .wr_data  (wr_data),
         .shd_en   (shd_en[i]),
         .ld_mode  (ld_mode[i]),
         .tick     (tick),
         .cnt_up   (cnt_up),
         .cnt      (cnt),
         .ev_zero  (ev_zero),
         .ev_prd   (ev_prd),
         .active   (cmp_act[i]),
         .ev_match (ev_cmp[i])
      );
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_out
      dpwm_aq aq_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .ev_zero (ev_zero),
         .ev_cmp  (ev_cmp),
         .cfg     (act_cfg[i]),
         .pwm     (pwm[i])
      );
   end

   assign pwm_a = pwm[0];
   assign pwm_b = pwm[1];

endmodule

// File: rtl/dpwm_gen_chk.sv
module dpwm_gen_chk
   import dpwm_pkg::*;
#(
   parameter int CW   = 16,
   parameter int DIVW = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic            tick,
   input logic [CW-1:0]   cnt,
   input logic [CW-1:0]   prd,
   input cnt_mode_e       mode,
   input logic [DIVW-1:0] div_sel,
   input logic            shd_a,
   input ld_mode_e        ld_a,
   input logic [CW-1:0]   cmp_a,
   input logic            out_a,
   input logic            out_b
);

   p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_a && !out_b));

   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div_sel != '0 && !wr_en) |=> !tick);

   p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == CM_UP && cnt >= prd) |=> (cnt == '0));

   p_down_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == CM_DOWN && cnt == '0) |=> (cnt == $past(prd)));

   p_down_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == CM_DOWN && cnt != '0) |=> ($stable(out_a) && $stable(out_b)));

   p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (shd_a && ld_a == LD_NEVER) |=> $stable(cmp_a));

   p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CM_FREEZE) |=> ($stable(out_a) && $stable(out_b) && $stable(cnt)));

endmodule

bind dpwm_gen dpwm_gen_chk #(.CW(CW), .DIVW(DIVW)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .tick    (tick),
   .cnt     (cnt),
   .prd     (prd),
   .mode    (mode),
   .div_sel (div_sel),
   .shd_a   (shd_en[0]),
   .ld_a    (ld_mode[0]),
   .cmp_a   (cmp_act[0]),
   .out_a   (pwm_a),
   .out_b   (pwm_b)
);

// File: tb/dpwm_gen_tb_top.sv
`timescale 1ns/1ps
module dpwm_gen_tb_top;

   localparam int LIM = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        pwm_a;
   logic        pwm_b;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dpwm_gen dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pwm_a   (pwm_a),
      .pwm_b   (pwm_b)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic outv(input int ch);
      return (ch == 0) ? pwm_a : pwm_b;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 3'(a);
      wr_data = 16'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic sync_rise(input int ch);
      int n = 0;
      while (outv(ch) !== 1'b0 && n < LIM) begin @(negedge clk); n++; end
      while (outv(ch) !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
   endtask

   task automatic measure(input int ch, output int hi, output int per);
      int lo = 0;
      hi = 0;
      sync_rise(ch);
      do begin @(negedge clk); hi++; end while (outv(ch) === 1'b1 && hi < LIM);
      do begin @(negedge clk); lo++; end while (outv(ch) === 1'b0 && lo < LIM);
      if (hi >= LIM || lo >= LIM) begin hi = -1; per = -1; end
      else per = hi + lo;
   endtask

   // Waits for a rising edge on A and writes in that same cycle; returns the high time of that pulse
   task automatic pulse_wr(input int a, input int d, output int hi);
      sync_rise(0);
      wr_en   = 1'b1;
      wr_addr = 3'(a);
      wr_data = 16'(d);
      hi = 0;
      do begin @(negedge clk); wr_en = 1'b0; hi++; end while (pwm_a === 1'b1 && hi < LIM);
   endtask

   initial begin
      int hi, per, ones, sd;
      string tag;

      // R1: reset state
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      ones = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         ones += int'(pwm_a) + int'(pwm_b);
      end
      chk("R1 outputs low while frozen after reset", ones, 0);

      // R2 R3 R5: up-mode sweep with the reset actions
      for (int s = 0; s < 4; s++) begin
         for (int pi = 0; pi < 2; pi++) begin
            for (int ci = 0; ci < 3; ci++) begin
               int p, c, cb, dv;
               p  = (pi == 0) ? 3 : 6;
               c  = (ci == 2) ? p : ci + 1;
               cb = p - c + 1;
               dv = 1 << s;
               wr(0, s << 2);
               wr(1, p);
               wr(2, c);
               wr(3, cb);
               measure(0, hi, per);
               $sformat(tag, "R5 A high k=%0d P=%0d C=%0d", s, p, c);
               chk(tag, hi, c * dv);
               $sformat(tag, "R3 R2 A period k=%0d P=%0d", s, p);
               chk(tag, per, (p + 1) * dv);
               measure(1, hi, per);
               $sformat(tag, "R5 B high k=%0d P=%0d C=%0d", s, p, cb);
               chk(tag, hi, cb * dv);
               $sformat(tag, "R3 R2 B period k=%0d P=%0d", s, p);
               chk(tag, per, (p + 1) * dv);
            end
         end
      end

      // R2: largest divide select
      wr(0, 7 << 2);
      wr(1, 2);
      wr(2, 1);
      measure(0, hi, per);
      chk("R2 divide by 128 high", hi, 128);
      chk("R2 divide by 128 period", per, 384);

      // R3 R6 R4: down mode, toggle at zero, compare clear must not fire
      wr(0, 1);
      wr(1, 4);
      wr(2, 2);
      wr(4, 7);
      measure(0, hi, per);
      chk("R6 R4 down mode toggle high", hi, 5);
      chk("R3 down mode period", per, 10);

      // R3 R6: up-down mode, divide by 2
      wr(4, 6);
      wr(0, 2 | (1 << 2));
      wr(1, 5);
      wr(2, 2);
      measure(0, hi, per);
      chk("R6 up-down high (rising match only)", hi, 4);
      chk("R3 up-down period", per, 20);

      // R7: compare B wins over compare A on the same tick
      wr(0, 0);
      wr(1, 5);
      wr(2, 3);
      wr(3, 3);
      wr(4, 'h1A);
      measure(0, hi, per);
      chk("R7 B over A high", hi, 3);
      chk("R7 B over A period", per, 6);

      // R7: compare zero beats zero action
      wr(4, 6);
      wr(2, 0);
      repeat (20) @(negedge clk);
      ones = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         ones += int'(pwm_a);
      end
      chk("R7 compare zero keeps A low", ones, 0);

      // R8: immediate write during a pulse
      wr(0, 0);
      wr(1, 9);
      wr(2, 3);
      pulse_wr(2, 6, hi);
      chk("R8 immediate write affects current pulse", hi, 6);

      // R9: shadow with load never
      wr(2, 3);
      wr(0, (1 << 5) | (3 << 7));
      wr(2, 7);
      measure(0, hi, per);
      chk("R9 load-never keeps old compare (1)", hi, 3);
      measure(0, hi, per);
      chk("R9 load-never keeps old compare (2)", hi, 3);

      // R9: load at period
      wr(0, (1 << 5) | (1 << 7));
      measure(0, hi, per);
      chk("R9 period load applies shadow", hi, 7);
      pulse_wr(2, 5, sd);
      chk("R9 period load: current pulse unchanged", sd, 7);
      measure(0, hi, per);
      chk("R9 period load: next pulse updated", hi, 5);

      // R9: load at zero
      wr(0, 1 << 5);
      pulse_wr(2, 2, sd);
      chk("R9 zero load: current pulse unchanged", sd, 5);
      measure(0, hi, per);
      chk("R9 zero load: next pulse updated", hi, 2);
      chk("R9 zero load: period", per, 10);

      // R10: freeze while A is high
      wr(0, 0);
      wr(1, 6);
      wr(2, 6);
      sync_rise(0);
      wr(0, 3);
      ones = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         ones += int'(pwm_a);
      end
      chk("R10 frozen output A holds high", ones, 50);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule